// File: doc/BRIEF.md
# Serial Register Port with Status Header

This block is a full-duplex serial slave that gives a host controller access to a small register set over four wires: an active-low select, a serial clock, a data input and a data output. Every transfer is a fixed 24-bit word, most significant bit first in both directions. The host sends a command byte followed by a 16-bit data field. The command byte holds a 2-bit operation code in its top two bits and a 6-bit register address below them. At the same time the block returns an 8-bit status header followed by a 16-bit response word that depends on the command.

The register set is made up of the following:
- a writable control word and a writable configuration word, both driven out to the rest of the chip;
- a read-only status word supplied by the chip;
- a bank of read-only 8-bit identification bytes, selected through a separate operation code.

A sticky frame-error flag records any transfer that did not carry exactly 24 clocks. The flag is reported in the header and is cleared by a dedicated operation.

The serial pins are brought into the system clock domain through two-flop synchronisers and sampled edge by edge. The serial clock must therefore be slow compared with the system clock: each serial clock phase must last at least four system clocks. The data output has a separate drive-enable. When that enable is low, the pad is expected to be high impedance.

Top module: `spi_regif_top`

## Requirements
- R1: `spi_sdo_en` is low while the synchronised select is high, and high while it is low. This means the output stops driving within three system clocks of select rising.
- R2: After select falls and before the first rising serial clock, `spi_sdo` shows the global fault bit. The global fault bit is the OR of the frame-error flag, `tsd_i` and `uov_oc_i`.
- R3: The first 8 bits returned are a status header, captured on the first rising serial clock. From MSB to LSB the header is: global fault, frame error, 0, 0, `tsd_i`, `uov_oc_i`, `not_ready_i`, 0. Output bits change after falling serial clock edges and are sampled by the host on rising edges.
- R4: Operation code 01 (read) and operation code 10 (read-and-clear) return response data selected by address. Address 0x01 returns the control word, 0x02 returns the configuration word, 0x10 returns `status_word_i`, and any other address returns 0x0000.
- R5: A write (operation code 00) returns the addressed register's contents from before the write. The new value appears on `ctrl_reg_o` or `cfg_reg_o` only after select rises.
- R6: A transfer with any number of rising serial clocks other than 24 changes no register and sets the frame-error flag. Reads during such a transfer still return data.
- R7: A complete transfer with operation code 10 clears the frame-error flag. A complete transfer with operation code 01 or 11 leaves the flag as it is.
- R8: Operation code 11 reads the identification space. Addresses 0 to 4 return byte k of parameter `ID_BYTES` (bits 8k+7 down to 8k) in the upper byte, with the lower byte zero. Any other address returns 0x0000.
- R9: A write to the status address or to an unmapped address, and any non-write operation, leaves the control and configuration words unchanged.
- R10: After reset, the control and configuration words equal `CTRL_RESET` and `CFG_RESET` (both 0x0000 by default), and the frame-error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn_n | input | 1 | Active-low select from host |
| spi_sclk | input | 1 | Serial clock from host (idle low) |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_en | output | 1 | Drive enable for the data output pad |
| tsd_i | input | 1 | Thermal shutdown indication |
| uov_oc_i | input | 1 | Supply out-of-range or over-current indication |
| not_ready_i | input | 1 | Device not ready indication |
| status_word_i | input | 16 | Read-only status word |
| ctrl_reg_o | output | 16 | Control register value |
| cfg_reg_o | output | 16 | Configuration register value |

## Verification
The bench aims at the timing of the response word. A design that latched write data on the last clock edge instead of on select release would return the new value, or would commit truncated frames. A design that picked the response before the command byte was complete would return data for the wrong address. The bench sends frames of 20 and 25 clocks. A counter that wrapped, or that checked only for at least 24 edges, would let such frames write registers and would never raise the frame-error bit. Identification reads are checked for left alignment and for zero beyond the fifth byte, to catch a shifted or unbounded lookup. The first output bit is sampled before any clock arrives, to catch a design that drives a stale shift-register bit there.

// File: rtl/spi_regif_pkg.sv
// Package: shared constants and types for the serial register port.
// Assumes a fixed 24-bit frame: 8-bit command byte then 16-bit data.
package spi_regif_pkg;

    localparam int CMD_BITS   = 8;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = CMD_BITS + DATA_BITS;
    localparam int ADDR_BITS  = 6;

    typedef enum logic [1:0] {
        OP_WRITE    = 2'b00,
        OP_READ     = 2'b01,
        OP_READ_CLR = 2'b10,
        OP_READ_ID  = 2'b11
    } op_e;

    localparam logic [ADDR_BITS-1:0] ADDR_CTRL = 6'h01;
    localparam logic [ADDR_BITS-1:0] ADDR_CFG  = 6'h02;
    localparam logic [ADDR_BITS-1:0] ADDR_STAT = 6'h10;

    typedef struct packed {
        logic       gfault;
        logic       frame_err;
        logic [1:0] rsv_hi;
        logic       tsd;
        logic       uov_oc;
        logic       not_ready;
        logic       rsv_lo;
    } stat_byte_t;

endpackage

// File: rtl/spi_regif_sync.sv
// Module: multi-stage flop synchroniser for asynchronous pins.
// Assumes each input changes slowly relative to clk; RST_VAL sets the reset level.
module spi_regif_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the asynchronous pins
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= RST_VAL;
                else        stage[0] <= d;
            end
        end else begin : g_next
            // Later stages: settle the captured value
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/spi_regif_frame.sv
// Module: frame engine. Detects serial clock and select edges on synchronised
// pins, shifts in the command and data, and drives the response bit stream.
// Assumes SCLK idles low, input sampled on rising edges, output changed on falling.
module spi_regif_frame
    import spi_regif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csn_s,
    input  logic                 sclk_s,
    input  logic                 sdi_s,
    input  logic                 gfault_i,
    input  logic [CMD_BITS-1:0]  stat_byte_i,
    input  logic [DATA_BITS-1:0] rd_data_i,
    output logic [CMD_BITS-1:0]  cmd_o,
    output logic [DATA_BITS-1:0] wdata_o,
    output logic                 commit_o,
    output logic                 abort_o,
    output logic                 sdo_o,
    output logic                 sdo_en_o
);

    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] RISE_MAX = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FALL_MAX = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    logic                  sclk_q, csn_q;
    logic                  sclk_rise, sclk_fall, csn_fall, csn_rise;
    logic [CNT_W-1:0]      rise_cnt, fall_cnt;
    logic [DATA_BITS-1:0]  rx_sr;
    logic [CMD_BITS-1:0]   cmd_q;
    logic                  cmd_done;
    logic                  loaded;
    logic [CMD_BITS-1:0]   stat_snap;
    logic [DATA_BITS-1:0]  data_snap;
    logic [FRAME_BITS-1:0] tx_word;

    // Previous-cycle copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q & ~csn_s;
    assign sclk_fall = ~sclk_s & sclk_q & ~csn_s;
    assign csn_fall  = ~csn_s & csn_q;
    assign csn_rise  = csn_s & ~csn_q;

    // Receive path: bit counting, command capture and data shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            rx_sr    <= '0;
            cmd_q    <= '0;
            cmd_done <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            if (csn_fall) begin
                rise_cnt <= '0;
            end else if (sclk_rise) begin
                rx_sr <= {rx_sr[DATA_BITS-2:0], sdi_s};
                if (rise_cnt != RISE_MAX) rise_cnt <= rise_cnt + 1'b1;
                if (rise_cnt == CMD_LAST) begin
                    cmd_q    <= {rx_sr[CMD_BITS-2:0], sdi_s};
                    cmd_done <= 1'b1;
                end
            end
        end
    end

    // Transmit path: header snapshot, response snapshot, output bit pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_cnt  <= '0;
            loaded    <= 1'b0;
            stat_snap <= '0;
            data_snap <= '0;
        end else begin
            if (csn_fall) begin
                fall_cnt  <= '0;
                loaded    <= 1'b0;
                data_snap <= '0;
            end else begin
                if (sclk_rise && rise_cnt == '0) begin
                    stat_snap <= stat_byte_i;
                    loaded    <= 1'b1;
                end
                if (sclk_fall && fall_cnt != FALL_MAX) fall_cnt <= fall_cnt + 1'b1;
                if (cmd_done) data_snap <= rd_data_i;
            end
        end
    end

    assign tx_word = {stat_snap, data_snap};

    // Output bit select: live fault bit until the first clock, then the frame
    always_comb begin
        sdo_o = 1'b0;
        if (!loaded)                   sdo_o = gfault_i;
        else if (fall_cnt < FALL_MAX)  sdo_o = tx_word[FALL_MAX - 1'b1 - fall_cnt];
    end

    assign sdo_en_o = ~csn_s;
    assign cmd_o    = cmd_q;
    assign wdata_o  = rx_sr;
    assign commit_o = csn_rise && (rise_cnt == FULL_CNT);
    assign abort_o  = csn_rise && (rise_cnt != FULL_CNT);

endmodule

// File: rtl/spi_regif_regs.sv
// Module: register file. Holds control, configuration and the frame-error flag,
// builds the status header and selects the response word for a command.
// Assumes commit/abort are single-cycle pulses at the end of a frame.
module spi_regif_regs
    import spi_regif_pkg::*;
#(
    parameter logic [DATA_BITS-1:0]  CTRL_RESET = '0,
    parameter logic [DATA_BITS-1:0]  CFG_RESET  = '0,
    parameter int                    ID_COUNT   = 5,
    parameter logic [ID_COUNT*8-1:0] ID_BYTES   = 40'h4E_02_5A_C3_18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CMD_BITS-1:0]  cmd_i,
    input  logic [DATA_BITS-1:0] wdata_i,
    input  logic                 commit_i,
    input  logic                 abort_i,
    input  logic                 tsd_i,
    input  logic                 uov_oc_i,
    input  logic                 not_ready_i,
    input  logic [DATA_BITS-1:0] status_word_i,
    output logic [DATA_BITS-1:0] rd_data_o,
    output logic [CMD_BITS-1:0]  stat_byte_o,
    output logic                 gfault_o,
    output logic                 frame_err_o,
    output logic [DATA_BITS-1:0] ctrl_o,
    output logic [DATA_BITS-1:0] cfg_o
);

    op_e                  op;
    logic [ADDR_BITS-1:0] addr;
    logic [7:0]           id_byte;
    stat_byte_t           stat;

    assign op   = op_e'(cmd_i[CMD_BITS-1 -: 2]);
    assign addr = cmd_i[ADDR_BITS-1:0];

    // Register updates on a completed frame; frame-error flag upkeep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o      <= CTRL_RESET;
            cfg_o       <= CFG_RESET;
            frame_err_o <= 1'b0;
        end else if (commit_i) begin
            if (op == OP_WRITE && addr == ADDR_CTRL) ctrl_o <= wdata_i;
            if (op == OP_WRITE && addr == ADDR_CFG)  cfg_o  <= wdata_i;
            if (op == OP_READ_CLR)                   frame_err_o <= 1'b0;
        end else if (abort_i) begin
            frame_err_o <= 1'b1;
        end
    end

    // Identification byte lookup
    always_comb begin
        id_byte = '0;
        for (int k = 0; k < ID_COUNT; k++) begin
            if (addr == ADDR_BITS'(k)) id_byte = ID_BYTES[8*k +: 8];
        end
    end

    // Response word selection by operation and address
    always_comb begin
        rd_data_o = '0;
        if (op == OP_READ_ID) begin
            rd_data_o = {id_byte, 8'h00};
        end else begin
            case (addr)
                ADDR_CTRL: rd_data_o = ctrl_o;
                ADDR_CFG:  rd_data_o = cfg_o;
                ADDR_STAT: rd_data_o = status_word_i;
                default:   rd_data_o = '0;
            endcase
        end
    end

    assign gfault_o = frame_err_o | tsd_i | uov_oc_i;

    // Status header assembly
    always_comb begin
        stat           = '0;
        stat.gfault    = gfault_o;
        stat.frame_err = frame_err_o;
        stat.tsd       = tsd_i;
        stat.uov_oc    = uov_oc_i;
        stat.not_ready = not_ready_i;
    end

    assign stat_byte_o = stat;

endmodule

// File: rtl/spi_regif_top.sv
// Module: top of the serial register port. Synchronises the serial pins,
// runs the frame engine and connects the register file.
// Assumes each serial clock phase spans at least four clk cycles.
module spi_regif_top
    import spi_regif_pkg::*;
#(
    parameter logic [15:0] CTRL_RESET = 16'h0000,
    parameter logic [15:0] CFG_RESET  = 16'h0000,
    parameter int          ID_COUNT   = 5,
    parameter logic [ID_COUNT*8-1:0] ID_BYTES = 40'h4E_02_5A_C3_18,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_csn_n,
    input  logic        spi_sclk,
    input  logic        spi_sdi,
    output logic        spi_sdo,
    output logic        spi_sdo_en,
    input  logic        tsd_i,
    input  logic        uov_oc_i,
    input  logic        not_ready_i,
    input  logic [15:0] status_word_i,
    output logic [15:0] ctrl_reg_o,
    output logic [15:0] cfg_reg_o
);

    logic                 csn_s, sclk_s, sdi_s;
    logic [CMD_BITS-1:0]  cmd;
    logic [DATA_BITS-1:0] wdata, rd_data;
    logic [CMD_BITS-1:0]  stat_byte;
    logic                 commit, abort, gfault, frame_err;

    spi_regif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn_n, spi_sclk, spi_sdi}),
        .q     ({csn_s, sclk_s, sdi_s})
    );

    spi_regif_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_s       (csn_s),
        .sclk_s      (sclk_s),
        .sdi_s       (sdi_s),
        .gfault_i    (gfault),
        .stat_byte_i (stat_byte),
        .rd_data_i   (rd_data),
        .cmd_o       (cmd),
        .wdata_o     (wdata),
        .commit_o    (commit),
        .abort_o     (abort),
        .sdo_o       (spi_sdo),
        .sdo_en_o    (spi_sdo_en)
    );

    spi_regif_regs #(
        .CTRL_RESET (CTRL_RESET),
        .CFG_RESET  (CFG_RESET),
        .ID_COUNT   (ID_COUNT),
        .ID_BYTES   (ID_BYTES)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd),
        .wdata_i       (wdata),
        .commit_i      (commit),
        .abort_i       (abort),
        .tsd_i         (tsd_i),
        .uov_oc_i      (uov_oc_i),
        .not_ready_i   (not_ready_i),
        .status_word_i (status_word_i),
        .rd_data_o     (rd_data),
        .stat_byte_o   (stat_byte),
        .gfault_o      (gfault),
        .frame_err_o   (frame_err),
        .ctrl_o        (ctrl_reg_o),
        .cfg_o         (cfg_reg_o)
    );

endmodule

// File: rtl/spi_regif_chk.sv
// Module: property checker for spi_regif_top, attached by bind below.
// Assumes synchronous active-low reset and two synchroniser stages.
module spi_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csn,
    input logic        sdo_en,
    input logic        commit,
    input logic        abort,
    input logic        ferr,
    input logic [15:0] ctrl,
    input logic [15:0] cfg
);

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctrl)); // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg)); // R9
    AST_ABORT_SETS_FERR: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ferr); // R6
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && abort)); // R6
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr && !commit) |=> ferr); // R7
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (csn && $past(csn) && $past(csn, 2)) |-> !sdo_en); // R1

endmodule

bind spi_regif_top spi_regif_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .csn    (spi_csn_n),
    .sdo_en (spi_sdo_en),
    .commit (commit),
    .abort  (abort),
    .ferr   (frame_err),
    .ctrl   (ctrl_reg_o),
    .cfg    (cfg_reg_o)
);

// File: tb/tb_spi_regif_top.sv
// Bench: bit-bangs 24-bit frames (plus short and long ones) and checks the
// returned header, response word and register outputs against a bench model.
module tb_spi_regif_top;

    localparam int HB = 8;                       // clk cycles per serial clock phase
    localparam logic [39:0] IDB = 40'h4E_02_5A_C3_18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic        tsd = 1'b0, uov = 1'b0, nrdy = 1'b0;
    logic [15:0] stw = 16'h0000;
    logic        sdo, sdo_en;
    logic [15:0] ctrl, cfg;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] ctrl_m = 16'h0000, cfg_m = 16'h0000;
    logic        ferr_m = 1'b0;

    always #2.5 clk = ~clk;

    spi_regif_top dut (
        .clk(clk), .rst_n(rst_n), .spi_csn_n(csn), .spi_sclk(sclk), .spi_sdi(sdi),
        .spi_sdo(sdo), .spi_sdo_en(sdo_en), .tsd_i(tsd), .uov_oc_i(uov),
        .not_ready_i(nrdy), .status_word_i(stw), .ctrl_reg_o(ctrl), .cfg_reg_o(cfg)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog: a hung run is a failure
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp<190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_data(input logic [1:0] op, input logic [5:0] a);
        if (op == 2'b11) return (a < 6'd5) ? {IDB[8*a +: 8], 8'h00} : 16'h0000;
        case (a)
            6'h01:   return ctrl_m;
            6'h02:   return cfg_m;
            6'h10:   return stw;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic [5:0] a);
        if (op == 2'b11) return "R8 id data";
        if (op == 2'b00) return "R5 write returns old";
        return "R4 read data";
    endfunction

    // One frame of nb rising clocks; checks header, data and register outputs
    task automatic frame(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d, input int nb);
        logic [23:0] w, resp, mask;
        logic        gf, first;
        logic [7:0]  es;
        logic [15:0] ed;
        w    = {op, a, d};
        resp = '0;
        gf   = ferr_m | tsd | uov;
        es   = {gf, ferr_m, 2'b00, tsd, uov, nrdy, 1'b0};
        ed   = exp_data(op, a);
        csn  = 1'b0;
        tick(HB);
        first = sdo;
        chk(sdo_en == 1'b1, "R1 drive on", {23'b0, sdo_en}, 24'h1);
        for (int i = 0; i < nb; i++) begin
            sdi = (i < 24) ? w[23-i] : 1'b0;
            tick(HB);
            if (i < 24) resp[23-i] = sdo;
            sclk = 1'b1;
            tick(HB);
            sclk = 1'b0;
        end
        tick(HB);
        csn = 1'b1;
        tick(HB);
        chk(sdo_en == 1'b0, "R1 drive off", {23'b0, sdo_en}, 24'h0);
        chk(first == gf, "R2 first bit", {23'b0, first}, {23'b0, gf});
        mask = (nb >= 24) ? 24'hFFFFFF : (24'hFFFFFF << (24 - nb));
        chk(resp[23:16] == es, "R3 header", {16'b0, resp[23:16]}, {16'b0, es});
        chk((resp & mask) == ({es, ed} & mask), tag_of(op, a), resp & mask, {es, ed} & mask);
        if (nb == 24) begin
            if (op == 2'b00 && a == 6'h01) ctrl_m = d;
            if (op == 2'b00 && a == 6'h02) cfg_m = d;
            if (op == 2'b10) ferr_m = 1'b0;
        end else begin
            ferr_m = 1'b1;
        end
        chk(ctrl == ctrl_m, (nb == 24) ? "R9 ctrl out" : "R6 ctrl kept", {8'b0, ctrl}, {8'b0, ctrl_m});
        chk(cfg == cfg_m, (nb == 24) ? "R5 cfg out" : "R6 cfg kept", {8'b0, cfg}, {8'b0, cfg_m});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R10: reset state
        chk(ctrl == 16'h0000, "R10 ctrl reset", {8'b0, ctrl}, 24'h0);
        chk(cfg == 16'h0000, "R10 cfg reset", {8'b0, cfg}, 24'h0);
        chk(sdo_en == 1'b0, "R1 idle", {23'b0, sdo_en}, 24'h0);
        // R5: write returns old value, then read back new
        frame(2'b00, 6'h01, 16'hA5C3, 24);
        frame(2'b00, 6'h01, 16'h1234, 24);
        frame(2'b01, 6'h01, 16'h0000, 24);
        frame(2'b00, 6'h02, 16'hBEEF, 24);
        // R9: writes to status and unmapped addresses ignored
        stw = 16'h5A0F;
        frame(2'b00, 6'h10, 16'hFFFF, 24);
        frame(2'b00, 6'h3F, 16'h7777, 24);
        frame(2'b01, 6'h3F, 16'h0000, 24);
        // R4: status word read
        frame(2'b01, 6'h10, 16'h0000, 24);
        // R8: identification bytes, left aligned, and beyond the bank
        for (int k = 0; k < 7; k++) frame(2'b11, 6'(k), 16'h0000, 24);
        // R6: short and long frames discard writes and set the error flag
        frame(2'b00, 6'h01, 16'hDEAD, 20);
        frame(2'b01, 6'h01, 16'h0000, 24);   // R7: plain read keeps flag
        frame(2'b00, 6'h02, 16'hCAFE, 25);
        frame(2'b10, 6'h02, 16'h0000, 24);   // R7: read-and-clear
        frame(2'b01, 6'h02, 16'h0000, 24);
        // R2, R3: fault inputs reflected in first bit and header
        tsd = 1'b1;
        frame(2'b01, 6'h01, 16'h0000, 24);
        tsd = 1'b0; uov = 1'b1; nrdy = 1'b1;
        frame(2'b01, 6'h02, 16'h0000, 24);
        uov = 1'b0; nrdy = 1'b0;
        // Random mix
        for (int n = 0; n < 50; n++) begin
            logic [1:0] op;
            logic [5:0] a;
            int         sel, nb;
            op  = 2'($urandom_range(0, 3));
            sel = $urandom_range(0, 5);
            a   = (sel == 0) ? 6'h01 : (sel == 1) ? 6'h02 : (sel == 2) ? 6'h10 :
                  (sel == 3) ? 6'($urandom_range(0, 4)) : 6'($urandom_range(0, 63));
            nb  = ($urandom_range(0, 9) == 0) ? (($urandom_range(0, 1) == 0) ? 21 : 25) : 24;
            tsd  = ($urandom_range(0, 7) == 0);
            uov  = ($urandom_range(0, 7) == 0);
            nrdy = ($urandom_range(0, 3) == 0);
            stw  = 16'($urandom);
            frame(op, a, 16'($urandom), nb);
        end
        summary();
        $finish;
    end

endmodule